// File: doc/BRIEF.md
# Calendar Real-Time Clock with Date/Time Alarm

This peripheral keeps wall-clock time as two packed calendar words rather than a binary seconds count. A programmable prescaler divides the input clock, nominally 32.768 kHz, into a one-second tick. On every tick the seconds advance, and carries ripple through minutes, hours, day of week, week of month, day of month, month and a full four-digit year. Month lengths follow the Gregorian leap-year rule.

Software reads and writes the clock over a simple single-cycle register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. A pair of alarm words is compared field for field against the calendar after each tick. A free-running periodic counter produces a programmable interval event. A status register gathers the event flags and their enables. It drives two interrupt lines: one for the one-second event, and one shared by the alarm and the periodic event.

Top module: `cal_rtc`

## Requirements
- R1: After reset the registers read as follows. Status (0x08) is 0. Divider word (0x0C) is 0x00007FFF. Period (0x38) is 0. The calendar reads year 2000, month 1, day 1, week 1, weekday 1, 00:00:00.
- R2: The divider word at 0x0C holds the divide value in bits 15:0 and a trim value in bits 31:16. Both read back as written. With divide value N, the calendar advances once every N+1 clock cycles.
- R3: A write to the time word (0x10) or the date word (0x14) loads it on that edge and restarts the prescaler. The next advance happens exactly N+1 cycles after the write.
- R4: The time word holds second in bits 5:0, minute in 11:6, hour in 16:12, weekday in 19:17 and week of month in 22:20. On a tick: 59 s wraps to 0 and carries into the minute; 59 min wraps to 0 and carries into the hour; 23 h wraps to 0 and carries into the day; weekday 7 wraps to 1.
- R5: The date word holds day in bits 4:0, month in 8:5 and year in 20:9. The last day of a month rolls to day 1 of the next month. February has 29 days when the year is divisible by 4 and either not by 100 or by 400. Month 12 rolls to month 1 and increments the year.
- R6: Whenever the day changes, the week of month becomes (day + 6) / 7 of the new day.
- R7: Status bit 1 (second flag) is set on every tick, whatever the enables. `irq_tick` is high exactly when bit 1 and its enable, bit 3, are both set.
- R8: On a tick, if status bit 5 (alarm enable) is set and both new calendar words equal the alarm words at 0x18 (time layout) and 0x1C (date layout), status bits 4 and 0 are set. With bit 5 clear, a match sets neither bit.
- R9: Flag bits 0, 1, 4 and 13 are cleared by writing 1 and unchanged by writing 0. Enable bits 2, 3, 5, 14 and 15 are plain read/write.
- R10: `irq_alarm` is high exactly when (bit 0 and bit 2), (bit 4 and bit 5) or (bit 13 and bit 14) are set.
- R11: While status bit 15 is set, bit 13 is set once every P+1 cycles, where P is bits 15:0 of the period register at 0x38. While bit 15 is clear, the periodic counter is held and bit 13 is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Time-base clock, nominally 32.768 kHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_tick | output | 1 | One-second interrupt request |
| irq_alarm | output | 1 | Alarm or periodic interrupt request |

## Verification
The checks that run on every cycle cover the following:
- After any tick, seconds, minutes and hours lie in their legal ranges.
- Every tick sets the second flag.
- A write of 1 to the second flag clears it.
- The alarm flag cannot rise while its enable is clear.
- The periodic flag rises only while periodic counting is on.
- The shared interrupt stays low when all of its enables are off.

Only the bench's scenarios can show the rest:
- the exact carry results at month, leap-year and year boundaries;
- the week-of-month recomputation;
- the one-full-second restart after a counter load;
- the alarm firing on a full two-word match;
- the exact periodic interval.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;

  // Register byte offsets (decoded by software drivers, kept fixed)
  localparam int OFF_STAT  = 'h08;
  localparam int OFF_DIV   = 'h0C;
  localparam int OFF_TIME  = 'h10;
  localparam int OFF_DATE  = 'h14;
  localparam int OFF_ATIME = 'h18;
  localparam int OFF_ADATE = 'h1C;
  localparam int OFF_PER   = 'h38;

  // Status bit positions
  localparam int SB_AL_DET  = 0;
  localparam int SB_HZ_DET  = 1;
  localparam int SB_AL_EN   = 2;
  localparam int SB_HZ_EN   = 3;
  localparam int SB_A1_DET  = 4;
  localparam int SB_A1_EN   = 5;
  localparam int SB_PER_DET = 13;
  localparam int SB_PER_EN  = 14;
  localparam int SB_PER_CNT = 15;

  // Calendar word layout
  localparam int TIME_W = 23;
  localparam int DATE_W = 21;

  function automatic logic is_leap(input logic [11:0] yr);
    logic div4, div100, div400;
    div4   = (yr[1:0] == 2'd0);
    div100 = ((yr % 12'd100) == 12'd0);
    div400 = ((yr % 12'd400) == 12'd0);
    return div4 && (!div100 || div400);
  endfunction

  function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [11:0] yr);
    case (mon)
      4'd2:                      month_len = is_leap(yr) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  endfunction

  function automatic logic [2:0] week_of(input logic [4:0] day);
    if (day <= 5'd7)       week_of = 3'd1;
    else if (day <= 5'd14) week_of = 3'd2;
    else if (day <= 5'd21) week_of = 3'd3;
    else if (day <= 5'd28) week_of = 3'd4;
    else                   week_of = 3'd5;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q >= div_i);
  assign tick_o = at_end && !restart_i;

  always_comb begin
    if (restart_i || at_end) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             hit_o
);

  logic [PER_W-1:0] cnt_q, cnt_d;

  assign hit_o = en_i && (cnt_q >= period_i);

  always_comb begin
    if (!en_i || hit_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
  import cal_rtc_pkg::*;
(
  input  logic [DATE_W-1:0] date_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [DATE_W-1:0] date_o,
  output logic [TIME_W-1:0] time_o
);

  logic [5:0]  sec, mnt, sec_n, mnt_n;
  logic [4:0]  hr, hr_n, day, day_n, mlen;
  logic [2:0]  dow, dow_n, wom, wom_n;
  logic [3:0]  mon, mon_n;
  logic [11:0] yr, yr_n;
  logic        c_sec, c_min, c_hr, c_day, c_mon;

  assign sec = time_i[5:0];
  assign mnt = time_i[11:6];
  assign hr  = time_i[16:12];
  assign dow = time_i[19:17];
  assign wom = time_i[22:20];
  assign day = date_i[4:0];
  assign mon = date_i[8:5];
  assign yr  = date_i[20:9];

  assign mlen = month_len(mon, yr);

  always_comb begin
    c_sec = (sec >= 6'd59);
    c_min = c_sec && (mnt >= 6'd59);
    c_hr  = c_min && (hr >= 5'd23);
    c_day = c_hr && (day >= mlen);
    c_mon = c_day && (mon >= 4'd12);

    sec_n = c_sec ? 6'd0 : sec + 6'd1;
    mnt_n = c_sec ? (c_min ? 6'd0 : mnt + 6'd1) : mnt;
    hr_n  = c_min ? (c_hr ? 5'd0 : hr + 5'd1) : hr;
    day_n = c_hr  ? (c_day ? 5'd1 : day + 5'd1) : day;
    dow_n = c_hr  ? ((dow >= 3'd7) ? 3'd1 : dow + 3'd1) : dow;
    wom_n = c_hr  ? week_of(day_n) : wom;
    mon_n = c_day ? (c_mon ? 4'd1 : mon + 4'd1) : mon;
    yr_n  = c_mon ? yr + 12'd1 : yr;
  end

  assign time_o = {wom_n, dow_n, hr_n, mnt_n, sec_n};
  assign date_o = {yr_n, mon_n, day_n};

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
  import cal_rtc_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DIV_W   = 16,
  parameter int TRIM_W  = 16,
  parameter int PER_W   = 16,
  parameter int RST_DIV = 32767
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_tick,
  output logic              irq_alarm
);

  localparam logic [DATE_W-1:0] RST_DATE = {12'd2000, 4'd1, 5'd1};
  localparam logic [TIME_W-1:0] RST_TIME = {3'd1, 3'd1, 5'd0, 6'd0, 6'd0};

  // Address decode
  logic wr_stat, wr_div, wr_time, wr_date, wr_atime, wr_adate, wr_per, cnt_wr;
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_div   = bus_wr && (bus_addr == ADDR_W'(OFF_DIV));
  assign wr_time  = bus_wr && (bus_addr == ADDR_W'(OFF_TIME));
  assign wr_date  = bus_wr && (bus_addr == ADDR_W'(OFF_DATE));
  assign wr_atime = bus_wr && (bus_addr == ADDR_W'(OFF_ATIME));
  assign wr_adate = bus_wr && (bus_addr == ADDR_W'(OFF_ADATE));
  assign wr_per   = bus_wr && (bus_addr == ADDR_W'(OFF_PER));
  assign cnt_wr   = wr_time || wr_date;

  // State
  logic [DATE_W-1:0] date_q, date_d, date_step, adate_q, adate_d;
  logic [TIME_W-1:0] time_q, time_d, time_step, atime_q, atime_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [TRIM_W-1:0] trim_q, trim_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic al_det_q, al_det_d, hz_det_q, hz_det_d, a1_det_q, a1_det_d, per_det_q, per_det_d;
  logic al_en_q, al_en_d, hz_en_q, hz_en_d, a1_en_q, a1_en_d;
  logic per_en_q, per_en_d, per_cnt_q, per_cnt_d;

  logic tick, per_hit, alarm_hit;

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_i(div_q), .restart_i(cnt_wr), .tick_o(tick)
  );

  rtc_periodic #(.PER_W(PER_W)) u_periodic (
    .clk(clk), .rst_n(rst_n), .en_i(per_cnt_q), .period_i(per_q), .hit_o(per_hit)
  );

  rtc_cal_next u_next (
    .date_i(date_q), .time_i(time_q), .date_o(date_step), .time_o(time_step)
  );

  assign alarm_hit = tick && a1_en_q && (date_step == adate_q) && (time_step == atime_q);

  // Next-state: configuration and calendar
  always_comb begin
    div_d   = wr_div   ? bus_wdata[DIV_W-1:0]       : div_q;
    trim_d  = wr_div   ? bus_wdata[16 +: TRIM_W]    : trim_q;
    per_d   = wr_per   ? bus_wdata[PER_W-1:0]       : per_q;
    atime_d = wr_atime ? bus_wdata[TIME_W-1:0]      : atime_q;
    adate_d = wr_adate ? bus_wdata[DATE_W-1:0]      : adate_q;

    if (wr_time)   time_d = bus_wdata[TIME_W-1:0];
    else if (tick) time_d = time_step;
    else           time_d = time_q;

    if (wr_date)   date_d = bus_wdata[DATE_W-1:0];
    else if (tick) date_d = date_step;
    else           date_d = date_q;
  end

  // Next-state: status (set wins over write-one-to-clear)
  always_comb begin
    al_det_d  = (al_det_q  && !(wr_stat && bus_wdata[SB_AL_DET]))  || alarm_hit;
    hz_det_d  = (hz_det_q  && !(wr_stat && bus_wdata[SB_HZ_DET]))  || tick;
    a1_det_d  = (a1_det_q  && !(wr_stat && bus_wdata[SB_A1_DET]))  || alarm_hit;
    per_det_d = (per_det_q && !(wr_stat && bus_wdata[SB_PER_DET])) || per_hit;
    al_en_d   = wr_stat ? bus_wdata[SB_AL_EN]   : al_en_q;
    hz_en_d   = wr_stat ? bus_wdata[SB_HZ_EN]   : hz_en_q;
    a1_en_d   = wr_stat ? bus_wdata[SB_A1_EN]   : a1_en_q;
    per_en_d  = wr_stat ? bus_wdata[SB_PER_EN]  : per_en_q;
    per_cnt_d = wr_stat ? bus_wdata[SB_PER_CNT] : per_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= DIV_W'(RST_DIV);
      trim_q    <= '0;
      per_q     <= '0;
      atime_q   <= '0;
      adate_q   <= '0;
      time_q    <= RST_TIME;
      date_q    <= RST_DATE;
      al_det_q  <= 1'b0;
      hz_det_q  <= 1'b0;
      a1_det_q  <= 1'b0;
      per_det_q <= 1'b0;
      al_en_q   <= 1'b0;
      hz_en_q   <= 1'b0;
      a1_en_q   <= 1'b0;
      per_en_q  <= 1'b0;
      per_cnt_q <= 1'b0;
    end else begin
      div_q     <= div_d;
      trim_q    <= trim_d;
      per_q     <= per_d;
      atime_q   <= atime_d;
      adate_q   <= adate_d;
      time_q    <= time_d;
      date_q    <= date_d;
      al_det_q  <= al_det_d;
      hz_det_q  <= hz_det_d;
      a1_det_q  <= a1_det_d;
      per_det_q <= per_det_d;
      al_en_q   <= al_en_d;
      hz_en_q   <= hz_en_d;
      a1_en_q   <= a1_en_d;
      per_en_q  <= per_en_d;
      per_cnt_q <= per_cnt_d;
    end
  end

  // Read mux
  logic [31:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[SB_AL_DET]  = al_det_q;
    stat_word[SB_HZ_DET]  = hz_det_q;
    stat_word[SB_AL_EN]   = al_en_q;
    stat_word[SB_HZ_EN]   = hz_en_q;
    stat_word[SB_A1_DET]  = a1_det_q;
    stat_word[SB_A1_EN]   = a1_en_q;
    stat_word[SB_PER_DET] = per_det_q;
    stat_word[SB_PER_EN]  = per_en_q;
    stat_word[SB_PER_CNT] = per_cnt_q;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_STAT):  bus_rdata = stat_word;
      ADDR_W'(OFF_DIV):   bus_rdata = 32'(div_q) | (32'(trim_q) << 16);
      ADDR_W'(OFF_TIME):  bus_rdata = 32'(time_q);
      ADDR_W'(OFF_DATE):  bus_rdata = 32'(date_q);
      ADDR_W'(OFF_ATIME): bus_rdata = 32'(atime_q);
      ADDR_W'(OFF_ADATE): bus_rdata = 32'(adate_q);
      ADDR_W'(OFF_PER):   bus_rdata = 32'(per_q);
      default:            bus_rdata = '0;
    endcase
  end

  assign irq_tick  = hz_det_q && hz_en_q;
  assign irq_alarm = (al_det_q && al_en_q) || (a1_det_q && a1_en_q) || (per_det_q && per_en_q);

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk
  import cal_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_stat,
  input logic [31:0]       bus_wdata,
  input logic [TIME_W-1:0] time_q,
  input logic              hz_det_q,
  input logic              a1_det_q,
  input logic              a1_en_q,
  input logic              al_en_q,
  input logic              per_en_q,
  input logic              per_cnt_q,
  input logic              per_det_q,
  input logic              irq_alarm
);

  // R7
  hz_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> hz_det_q);

  // R9
  hz_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[SB_HZ_DET] && !tick) |=> !hz_det_q);

  // R4
  time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_q[5:0] < 6'd60 && time_q[11:6] < 6'd60 && time_q[16:12] < 5'd24));

  // R8
  alarm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!a1_en_q && !a1_det_q) |=> !a1_det_q);

  // R11
  periodic_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_cnt_q && !per_det_q) |=> !per_det_q);

  // R10
  alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!al_en_q && !a1_en_q && !per_en_q) |-> !irq_alarm);

endmodule

bind cal_rtc cal_rtc_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_stat(wr_stat), .bus_wdata(bus_wdata),
  .time_q(time_q), .hz_det_q(hz_det_q), .a1_det_q(a1_det_q), .a1_en_q(a1_en_q),
  .al_en_q(al_en_q), .per_en_q(per_en_q), .per_cnt_q(per_cnt_q),
  .per_det_q(per_det_q), .irq_alarm(irq_alarm)
);

// File: tb/test_cal_rtc.sv
module test_cal_rtc;

  localparam logic [7:0] A_STAT = 8'h08, A_DIV = 8'h0C, A_TIME = 8'h10, A_DATE = 8'h14;
  localparam logic [7:0] A_ATIME = 8'h18, A_ADATE = 8'h1C, A_PER = 8'h38;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_tick, irq_alarm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cal_rtc i_cal_rtc (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_tick(irq_tick), .irq_alarm(irq_alarm)
  );

  // ---------------- reference model ----------------
  function automatic bit leap(int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int mdays(int y, int m);
    if (m == 2) return leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] pk_date(int y, int m, int d);
    return (y << 9) | (m << 5) | d;
  endfunction

  function automatic logic [31:0] pk_time(int d, int dow, int h, int mi, int s);
    return (((d + 6) / 7) << 20) | (dow << 17) | (h << 12) | (mi << 6) | s;
  endfunction

  function automatic void advance(inout int y, inout int m, inout int d, inout int dow,
                                  inout int h, inout int mi, inout int s);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; dow = (dow == 7) ? 1 : dow + 1; d++;
          if (d > mdays(y, m)) begin
            d = 1; m++;
            if (m == 13) begin m = 1; y++; end
          end
        end
      end
    end
  endfunction

  // ---------------- bus helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Load a calendar value, check it holds for div edges, then advances on the next.
  task automatic step_chk(input string req, input int div, input int y, input int m, input int d,
                          input int dow, input int h, input int mi, input int s);
    logic [31:0] rv;
    wr(A_DATE, pk_date(y, m, d));
    wr(A_TIME, pk_time(d, dow, h, mi, s));
    idle(div);
    rd(A_TIME, rv);
    chk("R3 hold before full period", rv, pk_time(d, dow, h, mi, s));
    idle(1);
    advance(y, m, d, dow, h, mi, s);
    rd(A_TIME, rv);
    chk(req, rv, pk_time(d, dow, h, mi, s));
    rd(A_DATE, rv);
    chk(req, rv, pk_date(y, m, d));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] rv;
    int unsigned seed;
    seed = $urandom(32'd20240611);

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset values (sampled before the first tick, which is 32768 cycles away)
    rd(A_STAT, rv); chk("R1 status", rv, 32'h0);
    rd(A_DIV, rv);  chk("R1 divider", rv, 32'h0000_7FFF);
    rd(A_PER, rv);  chk("R1 period", rv, 32'h0);
    rd(A_DATE, rv); chk("R1 date", rv, pk_date(2000, 1, 1));
    rd(A_TIME, rv); chk("R1 time", rv, pk_time(1, 1, 0, 0, 0));
    chk("R1 irq lines", {30'd0, irq_tick, irq_alarm}, 32'h0);

    // R2 divider/trim readback
    wr(A_DIV, 32'h0005_0003);
    rd(A_DIV, rv); chk("R2 divider/trim readback", rv, 32'h0005_0003);

    // Directed calendar corners, divider 3
    step_chk("R4 hour carry", 3, 2010, 5, 12, 3, 10, 59, 59);
    step_chk("R5 year rollover", 3, 2099, 12, 31, 7, 23, 59, 59);
    step_chk("R5 century not leap", 3, 2100, 2, 28, 2, 23, 59, 59);
    step_chk("R5 400-year leap", 3, 2000, 2, 28, 1, 23, 59, 59);
    step_chk("R5 leap day end", 3, 2024, 2, 29, 4, 23, 59, 59);
    step_chk("R6 week change", 3, 2023, 8, 7, 5, 23, 59, 59);
    step_chk("R6 30-day month", 3, 2023, 4, 30, 6, 23, 59, 59);

    // Random calendar states with biased carries
    for (int i = 0; i < 40; i++) begin
      int y, m, d, dow, h, mi, s;
      y   = 1 + int'($urandom % 4000);
      m   = 1 + int'($urandom % 12);
      d   = ($urandom % 3 == 0) ? mdays(y, m) : 1 + int'($urandom % mdays(y, m));
      dow = 1 + int'($urandom % 7);
      h   = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      mi  = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      s   = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      step_chk("R4 R5 R6 random step", 3, y, m, d, dow, h, mi, s);
    end

    // R2 tick period follows a different divider
    wr(A_DIV, 32'h0000_0007);
    step_chk("R2 divider 7 advance", 7, 2015, 3, 3, 2, 8, 8, 8);

    // R8 alarm fires on a full match when enabled; R10 alarm line
    wr(A_DIV, 32'h0000_0003);
    wr(A_ATIME, pk_time(15, 3, 12, 30, 46));
    wr(A_ADATE, pk_date(2031, 6, 15));
    wr(A_STAT, 32'h0000_2037);
    wr(A_DATE, pk_date(2031, 6, 15));
    wr(A_TIME, pk_time(15, 3, 12, 30, 45));
    idle(4);
    rd(A_STAT, rv); chk("R8 alarm flags set", rv & 32'h11, 32'h11);
    chk("R10 irq_alarm on alarm", {31'd0, irq_alarm}, 32'h1);
    wr(A_STAT, 32'h0000_0035);
    rd(A_STAT, rv); chk("R9 alarm flags cleared by one", rv & 32'h35, 32'h24);
    chk("R10 irq_alarm low after clear", {31'd0, irq_alarm}, 32'h0);

    // R8 no detection with alarm enable clear
    wr(A_STAT, 32'h0000_0015);
    wr(A_DATE, pk_date(2031, 6, 15));
    wr(A_TIME, pk_time(15, 3, 12, 30, 45));
    idle(4);
    rd(A_STAT, rv); chk("R8 no flag when disabled", rv & 32'h11, 32'h0);
    chk("R10 irq_alarm stays low", {31'd0, irq_alarm}, 32'h0);

    // R7 / R9 second flag and its interrupt, slow divider
    wr(A_DIV, 32'd999);
    wr(A_TIME, pk_time(1, 1, 0, 0, 0));
    wr(A_STAT, 32'h0000_2013);
    idle(999);
    rd(A_STAT, rv); chk("R7 second flag without enable", rv & 32'h0A, 32'h02);
    chk("R7 irq_tick gated by enable", {31'd0, irq_tick}, 32'h0);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, rv); chk("R9 write zero keeps flag", rv & 32'h0A, 32'h0A);
    chk("R7 irq_tick with enable", {31'd0, irq_tick}, 32'h1);
    wr(A_STAT, 32'h0000_000A);
    rd(A_STAT, rv); chk("R9 write one clears flag", rv & 32'h0A, 32'h08);
    chk("R7 irq_tick after clear", {31'd0, irq_tick}, 32'h0);

    // R11 periodic event every period+1 cycles
    wr(A_PER, 32'd5);
    rd(A_PER, rv); chk("R11 period readback", rv, 32'd5);
    wr(A_STAT, 32'h0000_C000);
    idle(5);
    rd(A_STAT, rv); chk("R11 not yet", rv & 32'h2000, 32'h0);
    idle(1);
    rd(A_STAT, rv); chk("R11 periodic flag", rv & 32'h2000, 32'h2000);
    chk("R10 irq_alarm on periodic", {31'd0, irq_alarm}, 32'h1);
    wr(A_STAT, 32'h0000_2000);
    idle(20);
    rd(A_STAT, rv); chk("R11 held when count off", rv & 32'h2000, 32'h0);
    chk("R10 irq_alarm quiet", {31'd0, irq_alarm}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule